// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts a single 128-bit plaintext block under a 128-bit key. It uses one shared round datapath for all rounds and finishes one round on each clock. The round keys are not computed ahead of time. Each one is derived from the previous round key in the same cycle that consumes it, so only one 128-bit key word group is ever stored.

A one-cycle `start` pulse takes in the plaintext and the key. Ten cycles later `done` pulses for one cycle and the full-width ciphertext appears. In that same cycle a byte stream begins: sixteen consecutive beats with `byte_valid` high, most significant byte first. The block accepts a new operation only after the stream has ended. Start pulses that arrive during the computation or during the stream are dropped.

Top module: `aes128_iter_enc`

## Requirements
- R1: After reset, `done` and `byte_valid` are 0 and `ciphertext` is all zeros.
- R2: Input byte k is bits [127-8k -: 8] of `plaintext` and of `key`. It sits in state column k/4, row k%4. The key is XORed into the state before the first round.
- R3: The core runs ten rounds. Rounds 1 to 9 perform byte substitution, row rotation (row r rotated left by r), column mixing and round-key addition. Round 10 leaves out column mixing. Key 000102…0F with plaintext 00112233…FF gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: Each round key is derived during the cycle that uses it. The derivation applies rotation, substitution and a round constant to the last word of the previous key. The constant starts at 01 and doubles in GF(2^8) each round, reaching 36 in round 10. Random keys and plaintexts match a reference model.
- R5: `done` goes high for exactly one cycle, in the 10th cycle after the clock edge that accepted `start`.
- R6: `ciphertext` takes the new result in the `done` cycle. It then holds that value until the next `done`.
- R7: `byte_valid` is high for exactly 16 consecutive cycles, beginning in the `done` cycle. Beat k carries bits [127-8k -: 8] of `ciphertext`.
- R8: A `start` pulse during the ten computing cycles is ignored. It changes neither the result nor the timing.
- R9: A `start` pulse during the byte stream is ignored. No further `done` follows it.
- R10: A `start` in the first cycle after the last stream beat is accepted.
- R11: Byte substitution reads a 256-entry lookup table. All-zero key and all-zero plaintext give 66e94bd4ef8a2c3b884cfa59ca342b2e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin encryption (taken only when idle) |
| plaintext | input | 128 | Block to encrypt, byte 0 in the MSBs |
| key | input | 128 | Cipher key, byte 0 in the MSBs |
| done | output | 1 | One-cycle pulse when the result is valid |
| ciphertext | output | 128 | Latest result, held until the next one |
| byte_valid | output | 1 | High for each of the 16 stream beats |
| byte_data | output | 8 | Current stream byte |

## Verification
The assertions check the control rules on every cycle:
- `done` is a single-cycle pulse that coincides with the first stream beat.
- The ciphertext stays stable through the rest of the stream.
- The round counter keeps advancing when a start pulse arrives mid-run.
- The stream does not stop early.
- The round constant reaches 36 in the last round.

The bench scenarios are needed for the data path. These are the byte mapping, the skipped column mixing in the final round, the correctness of the key derivation and the byte contents of each beat. They are shown by comparing known and random vectors against an independent reference model, and by checking the exact cycle in which `done` and each beat appear.

// File: rtl/aes128_pkg.sv
package aes128_pkg;
  localparam int NBYTES = 16;
  localparam int NROUNDS = 10;
  localparam int RND_W = $clog2(NROUNDS + 1);
  localparam int IDX_W = $clog2(NBYTES);

  typedef logic [127:0] blk_t;

  // multiply by x in GF(2^8), reduction polynomial 0x11b
  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, t;
    p = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ t;
      t = xt(t);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // substitution value: inverse as x^254, then the affine map
  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    logic [7:0] inv;
    inv = 8'h01;
    for (int i = 0; i < 254; i++) inv = gmul(inv, x);
    if (x == 8'h00) inv = 8'h00;
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  // byte at (row r, column c) is byte 4c+r; row r rotates left by r
  function automatic blk_t shift_rows(input blk_t b);
    blk_t o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = b[127-8*(4*((c+r)%4)+r) -: 8];
    return o;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] col);
    logic [7:0] a0, a1, a2, a3;
    a0 = col[31:24]; a1 = col[23:16]; a2 = col[15:8]; a3 = col[7:0];
    return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  endfunction

  function automatic blk_t mix_all(input blk_t b);
    blk_t o;
    for (int c = 0; c < 4; c++) o[127-32*c -: 32] = mix_col(b[127-32*c -: 32]);
    return o;
  endfunction
endpackage

// File: rtl/aes128_sbox.sv
module aes128_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [7:0] rom [256];

  // R11: table entries are fixed at elaboration
  for (genvar i = 0; i < 256; i++) begin : g_rom
    localparam logic [7:0] ENTRY = aes128_pkg::sbox_calc(8'(i));
    assign rom[i] = ENTRY;
  end

  assign dout = rom[din];
endmodule

// File: rtl/aes128_keystep.sv
module aes128_keystep
  import aes128_pkg::*;
(
  input  blk_t       rk_in,
  input  logic [7:0] rcon,
  output blk_t       rk_out
);
  logic [31:0] last_w, rot_w, sub_w, mix_t;
  logic [31:0] n0, n1, n2, n3;

  assign last_w = rk_in[31:0];
  assign rot_w  = {last_w[23:0], last_w[31:24]};

  for (genvar j = 0; j < 4; j++) begin : g_sub
    aes128_sbox u_sb (.din(rot_w[31-8*j -: 8]), .dout(sub_w[31-8*j -: 8]));
  end

  assign mix_t = sub_w ^ {rcon, 24'h0};
  assign n0 = rk_in[127:96] ^ mix_t;
  assign n1 = rk_in[95:64] ^ n0;
  assign n2 = rk_in[63:32] ^ n1;
  assign n3 = rk_in[31:0] ^ n2;
  assign rk_out = {n0, n1, n2, n3};
endmodule

// File: rtl/aes128_round.sv
module aes128_round
  import aes128_pkg::*;
(
  input  blk_t st_in,
  input  blk_t rkey,
  input  logic final_rnd,
  output blk_t st_out
);
  blk_t subbed, shifted, mixed;

  for (genvar i = 0; i < NBYTES; i++) begin : g_sb
    aes128_sbox u_sb (.din(st_in[127-8*i -: 8]), .dout(subbed[127-8*i -: 8]));
  end

  assign shifted = shift_rows(subbed);
  assign mixed   = mix_all(shifted);
  // R3: the final round bypasses column mixing
  assign st_out  = (final_rnd ? shifted : mixed) ^ rkey;
endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
  import aes128_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] plaintext,
  input  logic [127:0] key,
  output logic         done,
  output logic [127:0] ciphertext,
  output logic         byte_valid,
  output logic [7:0]   byte_data
);
  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_OUT} phase_t;

  phase_t           phase_q;
  blk_t             st_q, rk_q, ct_q;
  logic [7:0]       rc_q;
  logic [RND_W-1:0] rnd_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  blk_t next_key, round_out;
  logic start_taken, last_rnd, last_beat;
  logic [7:0] ct_bytes [NBYTES];

  assign start_taken = start && (phase_q == PH_IDLE);
  assign last_rnd    = (rnd_q == RND_W'(NROUNDS));
  assign last_beat   = (idx_q == IDX_W'(NBYTES - 1));

  aes128_keystep u_key (.rk_in(rk_q), .rcon(rc_q), .rk_out(next_key));
  aes128_round u_rnd (.st_in(st_q), .rkey(next_key), .final_rnd(last_rnd), .st_out(round_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      st_q    <= '0;
      rk_q    <= '0;
      ct_q    <= '0;
      rc_q    <= 8'h01;
      rnd_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_taken) begin
          st_q    <= plaintext ^ key;
          rk_q    <= key;
          rc_q    <= 8'h01;
          rnd_q   <= RND_W'(1);
          phase_q <= PH_RUN;
        end
        PH_RUN: begin
          st_q  <= round_out;
          rk_q  <= next_key;
          rc_q  <= xt(rc_q);
          rnd_q <= rnd_q + RND_W'(1);
          if (last_rnd) begin
            ct_q    <= round_out;
            done_q  <= 1'b1;
            idx_q   <= '0;
            phase_q <= PH_OUT;
          end
        end
        PH_OUT: begin
          idx_q <= idx_q + IDX_W'(1);
          if (last_beat) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_ctb
    assign ct_bytes[i] = ct_q[127-8*i -: 8];
  end

  assign done       = done_q;
  assign ciphertext = ct_q;
  assign byte_valid = (phase_q == PH_OUT);
  assign byte_data  = ct_bytes[idx_q];

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  stream_begin_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(byte_valid) |-> done);
  // R7
  done_beat_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> byte_valid);
  // R6
  ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !done) |-> $stable(ciphertext));
  // R8
  run_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && start && !last_rnd) |=> (rnd_q == $past(rnd_q) + RND_W'(1)));
  // R9
  out_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OUT && !last_beat) |=> (phase_q == PH_OUT));
  // R4
  rcon_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && last_rnd) |-> (rc_q == 8'h36));
endmodule

// File: tb/tb_aes128_iter_enc.sv
module tb_aes128_iter_enc;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] plaintext = '0;
  logic [127:0] key = '0;
  logic         done;
  logic [127:0] ciphertext;
  logic         byte_valid;
  logic [7:0]   byte_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  aes128_iter_enc dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------- reference model, written independently ----------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h11b << (i - 8);
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_sub(input logic [7:0] x);
    logic [7:0] inv = 8'h00;
    logic [7:0] s;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    s = 8'h63;
    for (int b = 0; b < 8; b++)
      s[b] = s[b] ^ inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8];
    return s;
  endfunction

  function automatic logic [127:0] m_enc(input logic [127:0] pt, input logic [127:0] k);
    logic [31:0] w [44];
    logic [7:0] st [16];
    logic [7:0] tmp [16];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    logic [127:0] res;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {m_sub(t[23:16]), m_sub(t[15:8]), m_sub(t[7:0]), m_sub(t[31:24])} ^ {rc, 24'h0};
        rc = m_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int i = 0; i < 16; i++) st[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) tmp[i] = m_sub(st[i]);
      for (int i = 0; i < 16; i++) st[i] = tmp[(i + 4*(i%4)) % 16];
      if (rd != 10)
        for (int c = 0; c < 4; c++) begin
          for (int r = 0; r < 4; r++)
            tmp[r] = m_mul(st[4*c+r], 8'h02) ^ m_mul(st[4*c+(r+1)%4], 8'h03)
                   ^ st[4*c+(r+2)%4] ^ st[4*c+(r+3)%4];
          for (int r = 0; r < 4; r++) st[4*c+r] = tmp[r];
        end
      for (int i = 0; i < 16; i++) st[i] ^= w[4*rd + i/4][31-8*(i%4) -: 8];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = st[i];
    return res;
  endfunction

  // one full operation; poke_run / poke_beat inject a stray start (0 = none)
  task automatic run_enc(input logic [127:0] pt, input logic [127:0] k,
                         input int poke_run, input int poke_beat, input string tag);
    logic [127:0] exp = m_enc(pt, k);
    plaintext = pt; key = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 10; c++) begin
      if (c == poke_run) begin start = 1'b1; plaintext = ~pt; key = ~k; end
      @(negedge clk);
      start = 1'b0;
      chk(done == (c == 10), {tag, " R5 done timing"}, 128'(done), 128'(c == 10));
    end
    chk(ciphertext == exp, {tag, " R4 ciphertext"}, ciphertext, exp);
    for (int b = 0; b < 16; b++) begin
      if (b > 0) begin
        if (b == poke_beat) begin start = 1'b1; plaintext = ~pt; end
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, {tag, " R9 no done in stream"}, 128'(done), 128'(0));
      end
      chk(byte_valid && byte_data == exp[127-8*b -: 8], {tag, " R7 beat"},
          {byte_valid, byte_data}, {1'b1, exp[127-8*b -: 8]});
    end
    @(negedge clk);
    chk(!byte_valid && !done, {tag, " R7 stream length"}, 128'(byte_valid), 128'(0));
    chk(ciphertext == exp, {tag, " R6 hold after stream"}, ciphertext, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] r_pt, r_k;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!done && !byte_valid && ciphertext == '0, "R1 reset state",
        {done, byte_valid, ciphertext[125:0]}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 known vector
    run_enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, 0, 0, "R3 vec");
    chk(ciphertext == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 R3 known vector",
        ciphertext, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // R11 all zero
    run_enc('0, '0, 0, 0, "R11 zero");
    chk(ciphertext == 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R11 zero vector",
        ciphertext, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);

    // R8 stray start mid-run, at the first and the last round boundary too
    run_enc(128'h0123456789abcdeffedcba9876543210, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, 5, 0, "R8 mid");
    run_enc(128'hdeadbeef00000000cafef00d11111111, 128'h1, 1, 0, "R8 first");
    run_enc(128'h5, 128'hffffffffffffffffffffffffffffffff, 9, 0, "R8 last");

    // R9 stray start during the stream, then no further done
    run_enc(128'h11, 128'h22, 0, 15, "R9 end");
    run_enc(128'h33, 128'h44, 0, 3, "R9 mid");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(!done && !byte_valid, "R9 no extra op", {done, byte_valid}, 2'b00);
    end

    // R10 back-to-back random operations (each starts right after the stream)
    for (int n = 0; n < 20; n++) begin
      r_pt = {$urandom, $urandom, $urandom, $urandom};
      r_k  = {$urandom, $urandom, $urandom, $urandom};
      run_enc(r_pt, r_k, 0, 0, "R10 random");
    end

    // R6 hold while idle with changing inputs
    plaintext = '1; key = '1;
    repeat (5) @(negedge clk);
    chk(ciphertext == m_enc(r_pt, r_k), "R6 hold idle", ciphertext, m_enc(r_pt, r_k));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule